// File: doc/BRIEF.md
# Synchronized clock stop gate

This block sits between an internal free-running clock and a set of clock outputs, and gates those outputs off and on in response to an asynchronous active-low stop pin. The pin passes through a synchronizer clocked by the internal clock. Each output's enable is held in a register that updates on the falling edge of that clock and is ANDed with it. As a result an output can only switch off or on while the clock is low. No runt pulse is produced, a stopped output rests low, and the first pulse after a restart is a full high phase.

The outputs fall into a primary group, which the stop always halts, two secondary groups that a 2-bit select adds to the stop set, and one free-running output that the stop never touches. Every output also has its own enable bit. After each restart the block keeps the stoppable outputs running for a minimum number of cycles. A stop that arrives inside this window is held and takes effect as soon as the window closes. With a two-stage synchronizer and a 100-cycle window, the block serves a processor-style stop. With one stage and a 10-cycle window, it serves a bus-style stop that has a free-running companion output.

Top module: `clk_stop_gate`

## Requirements
- R1: While the reset input is low, every clock output is low and the stopped flag is 0.
- R2: An enabled output that is not stopped gives one high pulse per internal clock cycle, and it is high exactly while the internal clock is high.
- R3: After the stop pin falls, and with the run window already expired, each stopped output gives exactly SYNC_STAGES more rising edges and is then held low. This is 2 for the processor setting, which is below 4, and 1 for the bus setting.
- R4: After the stop pin rises, the first SYNC_STAGES internal rising edges give no output pulse. The next edge starts a pulse that stays high for the full high phase of the internal clock.
- R5: After a restart from the stopped state, the stoppable outputs give at least MIN_RUN pulses before a new stop is honoured. A stop held during the window is applied when the window ends, so the count is then exactly MIN_RUN.
- R6: The group select encodes the stop set as follows: 2'b00 stops the primary group only; 2'b01 stops the primary and both secondary groups B and C; 2'b10 stops the primary group and group B; 2'b11 stops the primary group and group C.
- R7: An output whose enable bit is 0 stays low whatever the stop state.
- R8: The free-running output is never stopped by the stop pin. It follows only its own enable bit.
- R9: The stopped flag rises only after a synchronized stop request and falls only after the request has been withdrawn. It is 1 exactly while the primary group is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | internal running clock |
| rst_ni | input | 1 | asynchronous active-low reset, released synchronously inside |
| stop_ni | input | 1 | asynchronous active-low stop request |
| grp_sel_i | input | 2 | stop-set select for the secondary groups (R6 encoding) |
| en_a_i | input | W_A | per-output enables, primary group |
| en_b_i | input | W_B | per-output enables, secondary group B |
| en_c_i | input | W_C | per-output enables, secondary group C |
| en_free_i | input | 1 | enable of the free-running output |
| gclk_a_o | output | W_A | gated clocks, primary group |
| gclk_b_o | output | W_B | gated clocks, group B |
| gclk_c_o | output | W_C | gated clocks, group C |
| gclk_free_o | output | 1 | free-running clock output |
| stopped_o | output | 1 | 1 while the primary group is stopped |

## Verification
The bench builds two copies that share the stop pin and enables. One uses SYNC_STAGES=2 and MIN_RUN=100, with the group select driven. The other uses SYNC_STAGES=1 and MIN_RUN=10, with the select tied to 2'b00. Running both copies from one stimulus makes it possible to tell the off and on latencies of the two synchronizer depths apart edge by edge. It also separates the two exact window lengths after a one-cycle release pulse. On the deeper copy, all four group encodings can be observed while the shallower copy runs alongside.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } run_state_t;

  localparam logic [1:0] GRP_PRIMARY = 2'b00;
  localparam logic [1:0] GRP_ALL     = 2'b01;
  localparam logic [1:0] GRP_B       = 2'b10;
  localparam logic [1:0] GRP_C       = 2'b11;

  function automatic logic grp_hits_b(logic [1:0] sel);
    return (sel == GRP_ALL) || (sel == GRP_B);
  endfunction

  function automatic logic grp_hits_c(logic [1:0] sel);
    return (sel == GRP_ALL) || (sel == GRP_C);
  endfunction

endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n,
  output logic req
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= stop_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], stop_n};
      end
    end
  endgenerate

  assign req = ~chain_q[STAGES-1];
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import clk_stop_pkg::*;
#(
  parameter int MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic run_next
);
  localparam int CW = (MIN_RUN > 1) ? $clog2(MIN_RUN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_RUN - 1);

  run_state_t     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (state_q == ST_RUN) begin
      if (req && (cnt_q == CNT_LAST)) state_d = ST_HALT;
      else if (cnt_q != CNT_LAST)     cnt_d   = cnt_q + 1'b1;
    end else if (!req) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_next = (state_d == ST_RUN);
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] en,
  input  logic             hold,
  output logic [WIDTH-1:0] gclk
);
  logic [WIDTH-1:0] open_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) open_q[i] <= 1'b0;
        else        open_q[i] <= en[i] & ~hold;
      end
      assign gclk[i] = clk & open_q[i];
    end
  endgenerate
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int W_A         = 2,
  parameter int W_B         = 3,
  parameter int W_C         = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stop_ni,
  input  logic [1:0]     grp_sel_i,
  input  logic [W_A-1:0] en_a_i,
  input  logic [W_B-1:0] en_b_i,
  input  logic [W_C-1:0] en_c_i,
  input  logic           en_free_i,
  output logic [W_A-1:0] gclk_a_o,
  output logic [W_B-1:0] gclk_b_o,
  output logic [W_C-1:0] gclk_c_o,
  output logic           gclk_free_o,
  output logic           stopped_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_s;
  logic       stop_req;
  logic       run_next;
  logic       run_gate_q;
  logic       hold_a, hold_b, hold_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  stop_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk_i),
    .rst_n  (rst_s),
    .stop_n (stop_ni),
    .req    (stop_req)
  );

  stop_fsm #(.MIN_RUN(MIN_RUN)) i_fsm (
    .clk      (clk_i),
    .rst_n    (rst_s),
    .req      (stop_req),
    .run_next (run_next)
  );

  assign hold_a = ~run_next;
  assign hold_b = ~run_next & grp_hits_b(grp_sel_i);
  assign hold_c = ~run_next & grp_hits_c(grp_sel_i);

  always_ff @(negedge clk_i or negedge rst_s) begin
    if (!rst_s) run_gate_q <= 1'b1;
    else        run_gate_q <= run_next;
  end
  assign stopped_o = ~run_gate_q;

  clk_gate_bank #(.WIDTH(W_A)) i_bank_a (
    .clk(clk_i), .rst_n(rst_s), .en(en_a_i), .hold(hold_a), .gclk(gclk_a_o));
  clk_gate_bank #(.WIDTH(W_B)) i_bank_b (
    .clk(clk_i), .rst_n(rst_s), .en(en_b_i), .hold(hold_b), .gclk(gclk_b_o));
  clk_gate_bank #(.WIDTH(W_C)) i_bank_c (
    .clk(clk_i), .rst_n(rst_s), .en(en_c_i), .hold(hold_c), .gclk(gclk_c_o));
  clk_gate_bank #(.WIDTH(1)) i_bank_free (
    .clk(clk_i), .rst_n(rst_s), .en(en_free_i), .hold(1'b0), .gclk(gclk_free_o));

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int W_A     = 2,
  parameter int MIN_RUN = 100
) (
  input logic           clk,
  input logic           rst_n,
  input logic           stop_req,
  input logic [W_A-1:0] en_a,
  input logic           en_free,
  input logic [W_A-1:0] gclk_a,
  input logic           gclk_free,
  input logic           stopped
);
  logic [2:0]  arm_q;
  logic        armed;
  logic [15:0] run_len_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)              arm_q <= '0;
    else if (arm_q != 3'd5)  arm_q <= arm_q + 3'd1;
  end
  assign armed = (arm_q == 3'd5);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                    run_len_q <= '0;
    else if (stopped)              run_len_q <= '0;
    else if (run_len_q != 16'hFFFF) run_len_q <= run_len_q + 16'd1;
  end

  p_low_when_stopped_r3: assert property (@(negedge clk) disable iff (!rst_n)
    stopped |-> (gclk_a == '0));

  p_disabled_low_r7: assert property (@(negedge clk) disable iff (!rst_n || !armed)
    ((gclk_a & ~$past(en_a)) == '0));

  p_free_runs_r8: assert property (@(negedge clk) disable iff (!rst_n || !armed)
    $past(en_free) |-> gclk_free);

  p_min_run_r5: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(stopped) |-> (run_len_q >= 16'(MIN_RUN)));

  p_stop_needs_req_r9: assert property (@(negedge clk) disable iff (!rst_n || !armed)
    $rose(stopped) |-> $past(stop_req));

  p_restart_needs_release_r4: assert property (@(negedge clk) disable iff (!rst_n || !armed)
    $fell(stopped) |-> !$past(stop_req));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.W_A(W_A), .MIN_RUN(MIN_RUN)) i_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .stop_req  (stop_req),
  .en_a      (en_a_i),
  .en_free   (en_free_i),
  .gclk_a    (gclk_a_o),
  .gclk_free (gclk_free_o),
  .stopped   (stopped_o)
);

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_n;
  logic [1:0] grp_sel;
  logic [1:0] en_a;
  logic [2:0] en_b;
  logic [1:0] en_c;
  logic       en_free;

  logic [1:0] c_a, p_a;
  logic [2:0] c_b, p_b;
  logic [1:0] c_c, p_c;
  logic       c_free, p_free, c_stopped, p_stopped;

  int total = 0;
  int bad   = 0;
  int n_ca0 = 0, n_ca1 = 0, n_cb0 = 0, n_cc0 = 0, n_cfree = 0, n_pa0 = 0, n_pfree = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_stop_gate #(.W_A(2), .W_B(3), .W_C(2), .SYNC_STAGES(2), .MIN_RUN(100)) i_clk_stop_gate (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .grp_sel_i(grp_sel),
    .en_a_i(en_a), .en_b_i(en_b), .en_c_i(en_c), .en_free_i(en_free),
    .gclk_a_o(c_a), .gclk_b_o(c_b), .gclk_c_o(c_c), .gclk_free_o(c_free),
    .stopped_o(c_stopped));

  clk_stop_gate #(.W_A(2), .W_B(3), .W_C(2), .SYNC_STAGES(1), .MIN_RUN(10)) i_clk_stop_gate_pci (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .grp_sel_i(2'b00),
    .en_a_i(en_a), .en_b_i(en_b), .en_c_i(en_c), .en_free_i(en_free),
    .gclk_a_o(p_a), .gclk_b_o(p_b), .gclk_c_o(p_c), .gclk_free_o(p_free),
    .stopped_o(p_stopped));

  always @(posedge c_a[0]) n_ca0++;
  always @(posedge c_a[1]) n_ca1++;
  always @(posedge c_b[0]) n_cb0++;
  always @(posedge c_c[0]) n_cc0++;
  always @(posedge c_free) n_cfree++;
  always @(posedge p_a[0]) n_pa0++;
  always @(posedge p_free) n_pfree++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; stop_n = 1'b1; grp_sel = 2'b00;
    en_a = '1; en_b = '1; en_c = '1; en_free = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 primary low in reset", int'(c_a), 0);
    chk("R1 free low in reset", int'(c_free), 0);
    chk("R1 stopped flag in reset", int'(c_stopped), 0);
    rst_n = 1'b1;
    step(6);
  endtask

  task automatic t_run;
    int a0 = n_ca0, b0 = n_cb0, cc = n_cc0, fr = n_cfree, pa = n_pa0;
    step(20);
    chk("R2 primary pulses", n_ca0 - a0, 20);
    chk("R2 group B pulses", n_cb0 - b0, 20);
    chk("R2 group C pulses", n_cc0 - cc, 20);
    chk("R2 free pulses", n_cfree - fr, 20);
    chk("R2 bus copy pulses", n_pa0 - pa, 20);
    chk("R2 high with clock high", int'(c_a), 3);
    #4;
    chk("R2 low with clock low", int'(c_a), 0);
    #(-4 + CLK_PERIOD);
    step(120);
  endtask

  task automatic t_off_latency;
    int a0 = n_ca0, pa = n_pa0, b0 = n_cb0, fr = n_cfree, pf = n_pfree;
    stop_n = 1'b0;
    step(10);
    chk("R3 off latency two stages", n_ca0 - a0, 2);
    chk("R3 off latency one stage", n_pa0 - pa, 1);
    chk("R3 held low while clock high", int'(c_a), 0);
    chk("R6 select 00 leaves group B running", n_cb0 - b0, 10);
    chk("R8 free output ignores stop", n_cfree - fr, 10);
    chk("R8 bus copy free output ignores stop", n_pfree - pf, 10);
    chk("R9 stopped flag set", int'(c_stopped), 1);
    chk("R9 stopped flag set bus copy", int'(p_stopped), 1);
  endtask

  task automatic t_on_latency;
    int a0 = n_ca0, pa = n_pa0;
    stop_n = 1'b1;
    step(1);
    chk("R4 no pulse on first edge", n_ca0 - a0, 0);
    chk("R4 bus copy no pulse on first edge", n_pa0 - pa, 0);
    step(1);
    chk("R4 bus copy first pulse on second edge", n_pa0 - pa, 1);
    chk("R4 two stages no pulse on second edge", n_ca0 - a0, 0);
    step(1);
    chk("R4 two stages first pulse on third edge", n_ca0 - a0, 1);
    chk("R4 first pulse high early", int'(c_a[0]), 1);
    #2;
    chk("R4 first pulse high late in phase", int'(c_a[0]), 1);
    #(CLK_PERIOD - 2);
    chk("R9 stopped flag cleared", int'(c_stopped), 0);
    step(110);
  endtask

  task automatic t_groups;
    for (int s = 1; s < 4; s++) begin
      int a0, b0, cc;
      grp_sel = 2'(s);
      stop_n = 1'b0;
      step(6);
      a0 = n_ca0; b0 = n_cb0; cc = n_cc0;
      step(10);
      chk("R6 primary stopped", n_ca0 - a0, 0);
      chk("R6 group B", n_cb0 - b0, (s == 1 || s == 2) ? 0 : 10);
      chk("R6 group C", n_cc0 - cc, (s == 1 || s == 3) ? 0 : 10);
      stop_n = 1'b1;
      step(110);
    end
    grp_sel = 2'b00;
  endtask

  task automatic t_min_run;
    int a0, pa;
    stop_n = 1'b0;
    step(10);
    a0 = n_ca0; pa = n_pa0;
    stop_n = 1'b1;
    step(1);
    stop_n = 1'b0;
    step(150);
    chk("R5 minimum run two-stage copy", n_ca0 - a0, 100);
    chk("R5 minimum run bus copy", n_pa0 - pa, 10);
    chk("R5 pending stop applied", int'(c_stopped), 1);
  endtask

  task automatic t_enable;
    int a0, a1, fr;
    stop_n = 1'b1;
    step(110);
    en_a[1] = 1'b0; en_free = 1'b0;
    step(2);
    a0 = n_ca0; a1 = n_ca1; fr = n_cfree;
    step(10);
    chk("R7 disabled output stays low", n_ca1 - a1, 0);
    chk("R7 disabled free output low", n_cfree - fr, 0);
    chk("R7 neighbour keeps running", n_ca0 - a0, 10);
    chk("R7 disabled level while clock high", int'(c_a[1]), 0);
    en_a[1] = 1'b1; en_free = 1'b1;
    step(2);
  endtask

  initial begin
    t_reset();
    t_run();
    t_off_latency();
    t_on_latency();
    t_groups();
    t_min_run();
    t_enable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog all requirements act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule